// File: doc/BRIEF.md
# Flag-Carrying Add/Subtract Unit

This unit performs the five add and subtract operations of a small RISC core that report through a single status bit, called T. Each operation reads the two 32-bit operands A and B and the incoming T. It returns a 32-bit result and the next value of T. Depending on the operation, T means a carry-in and carry-out, a borrow-in and borrow-out, or a signed-overflow indication.

The arithmetic is combinational. An optional output slice, selected by the parameter `OUT_REG`, registers the result and the new T behind a valid/ready pair. On the input side, a request is taken on any cycle where `in_valid` and `in_ready` are both high. On the output side, a result is taken on any cycle where `out_valid` and `out_ready` are both high. With the slice present, a result that has not been taken stays frozen on the output. A new request is refused until the old result leaves, and the old result may leave in the same cycle that the new request is taken. With `OUT_REG = 0`, the handshake signals pass straight through and the data is combinational.

Top module: `tflag_arith_unit`

## Requirements
- R1: Op code 0 (add with carry) returns A + B + T modulo 2^32. The new T is the carry out of bit 31 from the complete sum.
- R2: Op code 2 (subtract with borrow) returns B − A − T modulo 2^32. The new T is 1 exactly when B < A + T (unsigned).
- R3: Op code 3 (negate with borrow) returns 0 − A − T modulo 2^32. The new T is 1 when A is nonzero or T is 1.
- R4: Op code 1 (add with overflow) returns A + B. The new T is 1 only when A and B have equal sign bits and bit 31 of the result differs from them. Otherwise the new T is 0.
- R5: Op code 4 (subtract with overflow) returns B − A. The new T is 1 only when the sign bits of A and B differ and bit 31 of the result differs from the sign bit of B. Otherwise the new T is 0.
- R6: When `in_flag_en` is 0, the new T equals the incoming T for every op code, and the result is still produced.
- R7: Op codes 5, 6 and 7 give a result of zero, and the new T equals the incoming T.
- R8: After reset, `out_valid` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result` and `out_t` do not change.
- R10: With the output slice present, `in_ready` is 0 whenever a result is held and `out_ready` is 0. A refused request does not reach the output.
- R11: A request taken in a cycle appears on the output in the next cycle. A result leaving and a new request arriving in the same cycle lose neither one. A result leaving with no new request leaves `out_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The unit accepts the request this cycle |
| in_op | input | 3 | Operation code (0 to 4 used) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_t | input | 1 | Incoming T flag |
| in_flag_en | input | 1 | Allows T to change |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | 32 | 32-bit result |
| out_t | output | 1 | Next value of T |

## Verification
The two functions that can meet in one cycle are draining a held result and accepting a fresh request.

The bench streams requests with `out_ready` high, so every cycle both takes a result and loads a new one, and each output is compared with a 33-bit reference model. It also stalls the consumer with a request waiting. During the stall it confirms that the request is refused and that the frozen output does not change. It then raises `out_ready` with the request still offered, and expects the waiting request on the output one cycle later with no item lost.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_CARRY = 3'd0,
    OP_ADD_OVF   = 3'd1,
    OP_SUB_BORROW = 3'd2,
    OP_NEG_BORROW = 3'd3,
    OP_SUB_OVF   = 3'd4
  } tfa_op_e;
endpackage

// File: rtl/tfa_add_chain.sv
// Two-step adder: (a + b) then + cin, carry-out of either step reported.
module tfa_add_chain #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] step1;
  logic [W:0] step2;

  always_comb begin
    step1 = {1'b0, a} + {1'b0, b};
    step2 = {1'b0, step1[W-1:0]} + {{W{1'b0}}, cin};
    sum   = step2[W-1:0];
    cout  = step1[W] | step2[W];
  end
endmodule

// File: rtl/tfa_sub_chain.sv
// Two-step subtractor: (m - s) then - bin, borrow of either step reported.
module tfa_sub_chain #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] m,
  input  logic [W-1:0] s,
  input  logic         bin,
  output logic [W-1:0] diff,
  output logic         bout
);
  logic [W:0] step1;
  logic [W:0] step2;

  always_comb begin
    step1 = {1'b0, m} - {1'b0, s};
    step2 = {1'b0, step1[W-1:0]} - {{W{1'b0}}, bin};
    diff  = step2[W-1:0];
    bout  = step1[W] | step2[W];
  end
endmodule

// File: rtl/tfa_core.sv
// Combinational operation select and T-flag resolution.
module tfa_core
  import tfa_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            t_cur,
  input  logic            flag_en,
  output logic [W-1:0]    res,
  output logic            t_next
);
  localparam int unsigned MSB = W - 1;

  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] sub_m;
  logic         sub_bin;
  logic [W-1:0] sub_diff;
  logic         sub_bout;
  logic         add_ovf;
  logic         sub_ovf;
  logic         op_t;
  logic         op_known;

  // The carry-in is used only by add-with-carry; the overflow add uses zero.
  assign add_cin = (op == OP_ADD_CARRY) ? t_cur : 1'b0;

  tfa_add_chain #(.W(W)) u_add (
    .a    (a),
    .b    (b),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  // Negation is a subtraction from zero on the same borrow chain.
  assign sub_m   = (op == OP_NEG_BORROW) ? '0 : b;
  assign sub_bin = ((op == OP_SUB_BORROW) || (op == OP_NEG_BORROW)) ? t_cur : 1'b0;

  tfa_sub_chain #(.W(W)) u_sub (
    .m    (sub_m),
    .s    (a),
    .bin  (sub_bin),
    .diff (sub_diff),
    .bout (sub_bout)
  );

  assign add_ovf = (a[MSB] == b[MSB]) && (add_sum[MSB] != a[MSB]);
  assign sub_ovf = (a[MSB] != b[MSB]) && (sub_diff[MSB] != b[MSB]);

  always_comb begin
    res      = '0;
    op_t     = t_cur;
    op_known = 1'b1;
    unique case (op)
      OP_ADD_CARRY:  begin res = add_sum;  op_t = add_cout; end
      OP_ADD_OVF:    begin res = add_sum;  op_t = add_ovf;  end
      OP_SUB_BORROW: begin res = sub_diff; op_t = sub_bout; end
      OP_NEG_BORROW: begin res = sub_diff; op_t = sub_bout; end
      OP_SUB_OVF:    begin res = sub_diff; op_t = sub_ovf;  end
      default:       begin res = '0;       op_known = 1'b0; end
    endcase
    t_next = (flag_en && op_known) ? op_t : t_cur;
  end
endmodule

// File: rtl/tfa_out_stage.sv
// Optional one-entry valid/ready output slice.
module tfa_out_stage #(
  parameter int unsigned W       = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_res,
  input  logic         d_t,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_res,
  output logic         q_t
);
  generate
    if (OUT_REG) begin : g_reg
      logic         full_q;
      logic [W-1:0] res_q;
      logic         t_q;
      logic         take;

      assign in_ready = !full_q || out_ready;
      assign take     = in_valid && in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          res_q  <= '0;
          t_q    <= 1'b0;
        end else begin
          if (take) begin
            full_q <= 1'b1;
            res_q  <= d_res;
            t_q    <= d_t;
          end else if (out_ready) begin
            full_q <= 1'b0;
          end
        end
      end

      assign out_valid = full_q;
      assign q_res     = res_q;
      assign q_t       = t_q;
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign q_res     = d_res;
      assign q_t       = d_t;
    end
  endgenerate
endmodule

// File: rtl/tflag_arith_unit.sv
module tflag_arith_unit
  import tfa_pkg::*;
#(
  parameter int unsigned W       = DATA_W,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic            in_t,
  input  logic            in_flag_en,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            out_t
);
  logic [W-1:0] core_res;
  logic         core_t;

  tfa_core #(.W(W)) u_core (
    .op      (in_op),
    .a       (in_a),
    .b       (in_b),
    .t_cur   (in_t),
    .flag_en (in_flag_en),
    .res     (core_res),
    .t_next  (core_t)
  );

  tfa_out_stage #(.W(W), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_res     (core_res),
    .d_t       (core_t),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_res     (out_result),
    .q_t       (out_t)
  );
endmodule

// File: rtl/tfa_checker.sv
module tfa_checker #(
  parameter int unsigned W       = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_op,
  input logic [W-1:0] in_a,
  input logic         in_t,
  input logic         in_flag_en,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_t
);
  generate
    if (OUT_REG) begin : g_chk
      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_t));

      assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

      assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

      assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

      assert_keep_t_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_flag_en |=> out_t == $past(in_t));

      assert_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_op > 3'd4) |=> (out_result == '0) && (out_t == $past(in_t)));

      assert_neg_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_flag_en && (in_op == 3'd3) && (in_a == '0) && !in_t
        |=> (out_result == '0) && !out_t);
    end
  endgenerate
endmodule

bind tflag_arith_unit tfa_checker #(.W(W), .OUT_REG(OUT_REG)) u_tfa_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_a       (in_a),
  .in_t       (in_t),
  .in_flag_en (in_flag_en),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_t      (out_t)
);

// File: tb/tflag_arith_unit_bench.sv
module tflag_arith_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_t = 1'b0;
  logic        in_flag_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_t;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tflag_arith_unit u_tflag_arith_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_t(in_t), .in_flag_en(in_flag_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_t(out_t)
  );

  // 33-bit reference model built from the requirements.
  function automatic logic [32:0] ref_model(input logic [2:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic t,
                                            input logic en);
    logic [32:0] w;
    logic [31:0] r;
    logic        nt;
    case (op)
      3'd0: begin w = {1'b0, a} + {1'b0, b} + {32'd0, t}; r = w[31:0]; nt = w[32]; end
      3'd1: begin w = {a[31], a} + {b[31], b}; r = w[31:0]; nt = w[32] ^ w[31]; end
      3'd2: begin w = {1'b0, b} - {1'b0, a} - {32'd0, t}; r = w[31:0]; nt = w[32]; end
      3'd3: begin w = 33'd0 - {1'b0, a} - {32'd0, t}; r = w[31:0]; nt = w[32]; end
      3'd4: begin w = {b[31], b} - {a[31], a}; r = w[31:0]; nt = w[32] ^ w[31]; end
      default: begin r = 32'd0; nt = t; end
    endcase
    if (!en || op > 3'd4) nt = t;
    return {nt, r};
  endfunction

  function automatic string req_of(input logic [2:0] op, input logic en);
    if (op > 3'd4) return "R7";
    if (!en) return "R6";
    case (op)
      3'd0: return "R1";
      3'd1: return "R4";
      3'd2: return "R2";
      3'd3: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual={v=%0b t=%0b r=%08h} expected={v=%0b t=%0b r=%08h}",
               req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // Present one request at a negedge; its result is checked at the next negedge.
  logic [32:0] pend_exp;
  string       pend_req;
  bit          pend = 1'b0;

  task automatic step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic t, input logic en);
    in_valid = 1'b1; out_ready = 1'b1;
    in_op = op; in_a = a; in_b = b; in_t = t; in_flag_en = en;
    @(posedge clk);
    @(negedge clk);
    // R11: accepted the cycle before, output now; previous one drained at the same edge.
    check(req_of(op, en), {out_valid, out_t, out_result}, {1'b1, ref_model(op, a, b, t, en)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [4];
    int unsigned seed_dummy;
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    seed_dummy = $urandom(32'hC0FFEE);

    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", {out_valid, 33'd0}, {1'b0, 33'd0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", {out_valid, 33'd0}, {1'b0, 33'd0});

    // Directed corners on all five operations, both T values (R1..R5).
    for (int op = 0; op < 5; op++)
      for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
          for (int t = 0; t < 2; t++)
            step(3'(op), corners[ia], corners[ib], 1'(t), 1'b1);

    // R6: flag enable low leaves T alone, result still produced.
    for (int op = 0; op < 8; op++) begin
      step(3'(op), 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0);
      step(3'(op), 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0);
    end

    // R7: unused codes give zero and keep T.
    for (int op = 5; op < 8; op++) begin
      step(3'(op), 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b1);
      step(3'(op), 32'hDEAD_BEEF, 32'h0000_0001, 1'b0, 1'b1);
    end

    // Constrained random: mostly legal ops, operands biased to edges.
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic [2:0]  op;
      a  = ($urandom % 4 == 0) ? corners[$urandom % 4] : $urandom;
      b  = ($urandom % 4 == 0) ? corners[$urandom % 4] : $urandom;
      op = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 5);
      step(op, a, b, 1'($urandom), ($urandom % 6) != 0);
    end

    // R9/R10/R11: back-pressure with a waiting request.
    begin
      logic [32:0] x_exp, y_exp;
      in_valid = 1'b1; out_ready = 1'b0;
      in_op = 3'd0; in_a = 32'hFFFF_FFFF; in_b = 32'h1; in_t = 1'b1; in_flag_en = 1'b1;
      x_exp = ref_model(3'd0, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1);
      // Last step left out_valid high; out_ready low now, so the previous result is held.
      @(posedge clk); @(negedge clk);
      // Previous random result held; request X not yet taken.
      check("R10", {in_ready, 33'd0}, {1'b0, 33'd0});
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R11", {out_valid, out_t, out_result}, {1'b1, x_exp});
      in_op = 3'd4; in_a = 32'h0000_0001; in_b = 32'h8000_0000; in_t = 1'b0;
      y_exp = ref_model(3'd4, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1);
      out_ready = 1'b0;
      @(posedge clk); @(negedge clk);
      // X held because out_ready is low; Y refused.
      check("R9", {out_valid, out_t, out_result}, {1'b1, x_exp});
      check("R10", {in_ready, 33'd0}, {1'b0, 33'd0});
      @(posedge clk); @(negedge clk);
      check("R9", {out_valid, out_t, out_result}, {1'b1, x_exp});
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      // X drained and Y taken at the same edge.
      check("R11", {out_valid, out_t, out_result}, {1'b1, y_exp});
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R11", {out_valid, 33'd0}, {1'b0, 33'd0});
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule